// File: doc/BRIEF.md
# Block-Copy DMA Engine with On-Device Byte Buffer

The engine copies a run of bytes between host memory and a byte buffer inside the device. Software uses a register port to load four 64-bit registers: source address, destination address, byte count and a command word. It then arms the engine by writing the command word with its start bit set. After a fixed number of clock cycles, the engine checks the buffer-side range against the buffer window. It then moves the bytes one by one over a byte-wide host memory request port with a valid/ready handshake. When the copy is done, the start bit drops and the engine can raise a one-cycle interrupt request.

The buffer appears in device address space at a fixed window base. Whichever of the two addresses points into the buffer is converted to a buffer offset by subtracting that base. The other address goes to the host after masking. While a copy is pending or running, all four registers are locked against writes. A rejected range never touches host memory. Instead it sets an error flag in the command word.

Top module: `blkdma`

## Requirements
- R1: After reset all four registers read 0, the host request valid is low and the interrupt output is 0.
- R2: While idle, the registers at offsets 0x80 (source), 0x88 (destination) and 0x90 (count) read back the full 64-bit value last written. The command word at 0x98 reads as bit 0 start, bit 1 direction, bit 2 interrupt enable, bit 3 range error, with all other bits 0.
- R3: A write to the command word with bit 0 clear is discarded: the command word keeps its value and no host request occurs.
- R4: While bit 0 of the command word is 1, writes to all four registers are ignored, including a second command write with bit 0 set.
- R5: Direction 0 copies host bytes into the buffer at offset (destination − 0x40000). Direction 1 copies buffer bytes from offset (source − 0x40000) out to host memory. Exactly count bytes move, one per cycle in which valid and ready are both high. While ready is low, the request is held unchanged.
- R6: The host byte address is (host-side register AND 0x0FFFFFFF) plus the byte index, starting at index 0.
- R7: The buffer-side address must lie in [0x40000, 0x41000), the count must be nonzero, and the end (address + count, without 64-bit wrap) must be below 0x41000. A range that breaks any of these clears bit 0, sets bit 3 and makes no host request. An accepted start clears bit 3.
- R8: At the end of a copy, bit 0 clears. If bit 2 was set, the interrupt output carries the value 0x100 (status bit 8) for exactly one cycle; otherwise it stays 0.
- R9: The first host request appears exactly START_DELAY clock cycles after the clock edge that accepts the start command (default 8).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr (combinational) |
| hreq_valid | output | 1 | Host byte request valid |
| hreq_write | output | 1 | 1 = write byte to host, 0 = read byte from host |
| hreq_addr | output | 64 | Host byte address |
| hreq_wdata | output | 8 | Byte sent to host on writes |
| hreq_ready | input | 1 | Host accepts the request this cycle |
| hrsp_rdata | input | 8 | Host byte returned in the accepting cycle of a read |
| irq_set | output | 32 | One-cycle interrupt status request, bit 8 on completion |

## Verification
The copy is run in both directions over a round trip. Host bytes are pulled into a buffer offset and then pushed out to a different host address. Only a correct offset, direction and byte order brings back the original pattern. Host ready is stalled on a repeating pattern in one direction and held high in the other, which separates a handshake-counting engine from one that counts cycles. A host address with high bits set shows whether masking happens. Range boundaries are probed on both sides of the window top, and with zero count, an address below the base and a wrapping end. Writes made during the start delay show whether the registers are locked.

// File: rtl/blkdma_pkg.sv
// Shared constants and types for the block-copy DMA engine.
// Assumes byte-addressed register offsets of 8 bits.
package blkdma_pkg;
    localparam logic [7:0] OFF_SRC = 8'h80;
    localparam logic [7:0] OFF_DST = 8'h88;
    localparam logic [7:0] OFF_CNT = 8'h90;
    localparam logic [7:0] OFF_CMD = 8'h98;

    localparam int CMD_RUN = 0;
    localparam int CMD_DIR = 1;
    localparam int CMD_IEN = 2;
    localparam int CMD_ERR = 3;

    typedef enum logic [1:0] {
        MV_IDLE = 2'd0,
        MV_WAIT = 2'd1,
        MV_XFER = 2'd2
    } mv_state_t;
endpackage

// File: rtl/blkdma_regs.sv
// Register file: source, destination, count and command word.
// Assumes the mover raises fin for one cycle per started command.
// All writes are dropped while the start bit is set.
module blkdma_regs
    import blkdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_we,
    input  logic [7:0]  reg_addr,
    input  logic [63:0] reg_wdata,
    output logic [63:0] reg_rdata,
    input  logic        fin,
    input  logic        fin_err,
    output logic        start,
    output logic        run_q,
    output logic        dir_q,
    output logic        ien_q,
    output logic        err_q,
    output logic [63:0] src_q,
    output logic [63:0] dst_q,
    output logic [63:0] cnt_q
);
    logic wr_ok;

    // Writes are only accepted while no command is pending or running.
    assign wr_ok = reg_we && !run_q;
    assign start = wr_ok && (reg_addr == OFF_CMD) && reg_wdata[CMD_RUN];

    // Address and count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
            cnt_q <= '0;
        end else if (wr_ok) begin
            if (reg_addr == OFF_SRC) src_q <= reg_wdata;
            if (reg_addr == OFF_DST) dst_q <= reg_wdata;
            if (reg_addr == OFF_CNT) cnt_q <= reg_wdata;
        end
    end

    // Command word: start, direction, interrupt enable, range error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            dir_q <= 1'b0;
            ien_q <= 1'b0;
            err_q <= 1'b0;
        end else if (start) begin
            run_q <= 1'b1;
            dir_q <= reg_wdata[CMD_DIR];
            ien_q <= reg_wdata[CMD_IEN];
            err_q <= 1'b0;
        end else if (fin) begin
            run_q <= 1'b0;
            if (fin_err) err_q <= 1'b1;
        end
    end

    // Read multiplexer.
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_SRC: reg_rdata = src_q;
            OFF_DST: reg_rdata = dst_q;
            OFF_CNT: reg_rdata = cnt_q;
            OFF_CMD: begin
                reg_rdata[CMD_RUN] = run_q;
                reg_rdata[CMD_DIR] = dir_q;
                reg_rdata[CMD_IEN] = ien_q;
                reg_rdata[CMD_ERR] = err_q;
            end
            default: reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/blkdma_window.sv
// Combinational range check of the buffer-side span against the window.
// Assumes 64-bit address and count; the end is computed without wrap.
module blkdma_window #(
    parameter logic [63:0] WIN_BASE  = 64'h40000,
    parameter int          BUF_BYTES = 4096,
    localparam int         OFFW      = $clog2(BUF_BYTES)
) (
    input  logic [63:0]     addr,
    input  logic [63:0]     cnt,
    output logic            ok,
    output logic [OFFW-1:0] off
);
    localparam logic [63:0] WIN_TOP = WIN_BASE + 64'(BUF_BYTES);

    logic [64:0] span_end;
    logic [63:0] rel;

    // Start inside window, nonzero length, end below the window top.
    always_comb begin
        span_end = {1'b0, addr} + {1'b0, cnt};
        rel      = addr - WIN_BASE;
        off      = rel[OFFW-1:0];
        ok       = (addr >= WIN_BASE) && (addr < WIN_TOP) && (cnt != 64'd0)
                && !span_end[64] && (span_end[63:0] < WIN_TOP);
    end
endmodule

// File: rtl/blkdma_mover.sv
// Start delay, range acceptance and byte-serial copy with the local buffer.
// Assumes the register inputs stay fixed from start until fin.
module blkdma_mover
    import blkdma_pkg::*;
#(
    parameter int          BUF_BYTES   = 4096,
    parameter logic [63:0] WIN_BASE    = 64'h40000,
    parameter logic [63:0] HOST_MASK   = 64'h0FFF_FFFF,
    parameter int          START_DELAY = 8,
    parameter int          IRQ_W       = 32,
    parameter int          IRQ_BIT     = 8,
    localparam int         OFFW        = $clog2(BUF_BYTES),
    localparam int         DLY_W       = $clog2(START_DELAY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             dir,
    input  logic             ien,
    input  logic [63:0]      src,
    input  logic [63:0]      dst,
    input  logic [63:0]      cnt,
    output logic             fin,
    output logic             fin_err,
    output logic             hreq_valid,
    output logic             hreq_write,
    output logic [63:0]      hreq_addr,
    output logic [7:0]       hreq_wdata,
    input  logic             hreq_ready,
    input  logic [7:0]       hrsp_rdata,
    output logic [IRQ_W-1:0] irq_set
);
    mv_state_t       st;
    logic [DLY_W-1:0] dly;
    logic [OFFW:0]   idx;
    logic [OFFW:0]   len_q;
    logic [OFFW-1:0] off_q;
    logic [63:0]     hbase_q;
    logic [7:0]      mem [BUF_BYTES];

    logic [63:0]     buf_side;
    logic [63:0]     host_side;
    logic            win_ok;
    logic [OFFW-1:0] win_off;
    logic            delay_done;
    logic            hs;
    logic            last;
    logic [OFFW-1:0] bidx;

    assign buf_side  = dir ? src : dst;
    assign host_side = dir ? dst : src;

    blkdma_window #(.WIN_BASE(WIN_BASE), .BUF_BYTES(BUF_BYTES)) u_win (
        .addr (buf_side),
        .cnt  (cnt),
        .ok   (win_ok),
        .off  (win_off)
    );

    // Handshake and end-of-phase decode.
    always_comb begin
        delay_done = (st == MV_WAIT) && (dly == DLY_W'(START_DELAY - 1));
        hs         = (st == MV_XFER) && hreq_ready;
        last       = hs && (idx == len_q - 1'b1);
        fin_err    = delay_done && !win_ok;
        fin        = fin_err || last;
        bidx       = off_q + idx[OFFW-1:0];
    end

    // Sequencer: idle, start delay, byte transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= MV_IDLE;
            dly     <= '0;
            idx     <= '0;
            len_q   <= '0;
            off_q   <= '0;
            hbase_q <= '0;
        end else begin
            case (st)
                MV_IDLE: if (start) begin
                    st  <= MV_WAIT;
                    dly <= '0;
                end
                MV_WAIT: begin
                    dly <= dly + 1'b1;
                    if (delay_done) begin
                        if (win_ok) begin
                            st      <= MV_XFER;
                            idx     <= '0;
                            len_q   <= cnt[OFFW:0];
                            off_q   <= win_off;
                            hbase_q <= host_side & HOST_MASK;
                        end else begin
                            st <= MV_IDLE;
                        end
                    end
                end
                MV_XFER: if (hs) begin
                    idx <= idx + 1'b1;
                    if (last) st <= MV_IDLE;
                end
                default: st <= MV_IDLE;
            endcase
        end
    end

    // Buffer fill from host reads.
    always_ff @(posedge clk) begin
        if (hs && !dir) mem[bidx] <= hrsp_rdata;
    end

    // One-cycle completion interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_set <= '0;
        else        irq_set <= (last && ien) ? (IRQ_W'(1) << IRQ_BIT) : '0;
    end

    assign hreq_valid = (st == MV_XFER);
    assign hreq_write = dir;
    assign hreq_addr  = hbase_q + 64'(idx);
    assign hreq_wdata = mem[bidx];
endmodule

// File: rtl/blkdma.sv
// Top of the block-copy DMA engine: register file plus mover.
// Assumes a single clock and synchronous active-low reset.
module blkdma #(
    parameter int          BUF_BYTES   = 4096,
    parameter logic [63:0] WIN_BASE    = 64'h40000,
    parameter logic [63:0] HOST_MASK   = 64'h0FFF_FFFF,
    parameter int          START_DELAY = 8,
    parameter int          IRQ_W       = 32,
    parameter int          IRQ_BIT     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [7:0]       reg_addr,
    input  logic [63:0]      reg_wdata,
    output logic [63:0]      reg_rdata,
    output logic             hreq_valid,
    output logic             hreq_write,
    output logic [63:0]      hreq_addr,
    output logic [7:0]       hreq_wdata,
    input  logic             hreq_ready,
    input  logic [7:0]       hrsp_rdata,
    output logic [IRQ_W-1:0] irq_set
);
    logic        start, fin, fin_err;
    logic        run_q, dir_q, ien_q, err_q;
    logic [63:0] src_q, dst_q, cnt_q;

    blkdma_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .fin       (fin),
        .fin_err   (fin_err),
        .start     (start),
        .run_q     (run_q),
        .dir_q     (dir_q),
        .ien_q     (ien_q),
        .err_q     (err_q),
        .src_q     (src_q),
        .dst_q     (dst_q),
        .cnt_q     (cnt_q)
    );

    blkdma_mover #(
        .BUF_BYTES   (BUF_BYTES),
        .WIN_BASE    (WIN_BASE),
        .HOST_MASK   (HOST_MASK),
        .START_DELAY (START_DELAY),
        .IRQ_W       (IRQ_W),
        .IRQ_BIT     (IRQ_BIT)
    ) u_mover (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .dir        (dir_q),
        .ien        (ien_q),
        .src        (src_q),
        .dst        (dst_q),
        .cnt        (cnt_q),
        .fin        (fin),
        .fin_err    (fin_err),
        .hreq_valid (hreq_valid),
        .hreq_write (hreq_write),
        .hreq_addr  (hreq_addr),
        .hreq_wdata (hreq_wdata),
        .hreq_ready (hreq_ready),
        .hrsp_rdata (hrsp_rdata),
        .irq_set    (irq_set)
    );
endmodule

// File: rtl/blkdma_checker.sv
// Protocol and state properties of the DMA engine, bound into blkdma.
module blkdma_checker #(
    parameter int IRQ_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hreq_valid,
    input logic             hreq_ready,
    input logic             hreq_write,
    input logic [63:0]      hreq_addr,
    input logic [IRQ_W-1:0] irq_set,
    input logic             run_q,
    input logic             err_q,
    input logic [63:0]      src_q,
    input logic [63:0]      dst_q,
    input logic [63:0]      cnt_q
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_valid && !hreq_ready |=> hreq_valid && $stable(hreq_addr) && $stable(hreq_write)); // R5

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hreq_valid |-> run_q); // R9

    AST_ERR_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> !hreq_valid); // R7

    AST_FROZEN_REGS: assert property (@(posedge clk) disable iff (!rst_n)
        run_q && $past(run_q) |-> $stable(src_q) && $stable(dst_q) && $stable(cnt_q)); // R4

    AST_IRQ_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set != '0 |-> irq_set == IRQ_W'(32'h100)); // R8

    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_set != '0 |=> irq_set == '0); // R8

    AST_IRQ_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_set[8]) |-> !run_q && $past(hreq_valid && hreq_ready)); // R8
endmodule

bind blkdma blkdma_checker #(.IRQ_W(IRQ_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hreq_valid (hreq_valid),
    .hreq_ready (hreq_ready),
    .hreq_write (hreq_write),
    .hreq_addr  (hreq_addr),
    .irq_set    (irq_set),
    .run_q      (run_q),
    .err_q      (err_q),
    .src_q      (src_q),
    .dst_q      (dst_q),
    .cnt_q      (cnt_q)
);

// File: tb/blkdma_bench.sv
// Directed bench for blkdma: one task per scenario, host memory modelled here.
module blkdma_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DELAY      = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_we;
    logic [7:0]  reg_addr;
    logic [63:0] reg_wdata;
    logic [63:0] reg_rdata;
    logic        hreq_valid, hreq_write, hreq_ready;
    logic [63:0] hreq_addr;
    logic [7:0]  hreq_wdata, hrsp_rdata;
    logic [31:0] irq_set;

    int checks = 0;
    int errors = 0;
    int hs_count = 0;
    int irq_count = 0;
    int cyc = 0;
    logic [63:0] first_addr;
    logic        stall_mode = 1'b0;
    logic [7:0]  host_mem [16384];

    always #(CLK_PERIOD / 2) clk = ~clk;

    blkdma #(.START_DELAY(DELAY)) u_blkdma (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .hreq_valid (hreq_valid),
        .hreq_write (hreq_write),
        .hreq_addr  (hreq_addr),
        .hreq_wdata (hreq_wdata),
        .hreq_ready (hreq_ready),
        .hrsp_rdata (hrsp_rdata),
        .irq_set    (irq_set)
    );

    assign hrsp_rdata = host_mem[hreq_addr[13:0]];

    // Host memory model and event counters.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (irq_set != 32'd0) irq_count <= irq_count + 1;
        if (hreq_valid && hreq_ready) begin
            if (hs_count == 0) first_addr <= hreq_addr;
            hs_count <= hs_count + 1;
            if (hreq_write) host_mem[hreq_addr[13:0]] <= hreq_wdata;
        end
    end

    // Host ready: stalls two cycles in three when stall_mode is on.
    always @(negedge clk) hreq_ready <= stall_mode ? ((cyc % 3) == 0) : 1'b1;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [63:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [63:0] c;
        for (int i = 0; i < 20000; i++) begin
            rd(8'h98, c);
            if (!c[0]) return;
        end
        check("R8 run clears", 64'd1, 64'd0);
    endtask

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 7) + 3);
    endfunction

    task automatic t_reset();
        logic [63:0] v;
        rd(8'h80, v); check("R1 src", v, 0);
        rd(8'h88, v); check("R1 dst", v, 0);
        rd(8'h90, v); check("R1 cnt", v, 0);
        rd(8'h98, v); check("R1 cmd", v, 0);
        check("R1 valid", 64'(hreq_valid), 0);
        check("R1 irq", 64'(irq_set), 0);
    endtask

    task automatic t_regs();
        logic [63:0] v;
        wr(8'h80, 64'hDEAD_BEEF_1234_5678); rd(8'h80, v); check("R2 src", v, 64'hDEAD_BEEF_1234_5678);
        wr(8'h88, 64'hFEDC_BA98_7654_3210); rd(8'h88, v); check("R2 dst", v, 64'hFEDC_BA98_7654_3210);
        wr(8'h90, 64'h8000_0000_0000_0001); rd(8'h90, v); check("R2 cnt", v, 64'h8000_0000_0000_0001);
    endtask

    task automatic t_norun();
        logic [63:0] v;
        int h0 = hs_count;
        wr(8'h98, 64'hFFFF_FFFF_FFFF_FFFE);
        rd(8'h98, v); check("R3 cmd kept", v, 0);
        repeat (DELAY + 4) @(negedge clk);
        check("R3 no request", 64'(hs_count - h0), 0);
    endtask

    // Host -> buffer with stalls, then buffer -> host: round trip.
    task automatic t_round_trip();
        logic [63:0] v;
        int h0, i0, k;
        stall_mode = 1'b1;
        wr(8'h80, 64'h0000_000F_0000_0100);
        wr(8'h88, 64'h40010);
        wr(8'h90, 64'd20);
        h0 = hs_count; i0 = irq_count;
        wr(8'h98, 64'h5);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R5 count in", 64'(hs_count - h0), 20);
        check("R6 masked addr", first_addr, 64'h100);
        check("R8 irq once", 64'(irq_count - i0), 1);
        rd(8'h98, v); check("R8 cmd after", v, 64'h4);
        stall_mode = 1'b0;
        wr(8'h80, 64'h40010);
        wr(8'h88, 64'h2000);
        h0 = hs_count; i0 = irq_count;
        wr(8'h98, 64'h3);
        // First request lands exactly DELAY cycles after the accepting edge.
        k = 0;
        while (!hreq_valid && k < 40) begin
            @(negedge clk); k++;
        end
        check("R9 start delay", 64'(k), DELAY);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R5 count out", 64'(hs_count - h0), 20);
        check("R8 no irq", 64'(irq_count - i0), 0);
        for (int i = 0; i < 20; i++)
            check("R5 round trip data", 64'(host_mem[14'h2000 + 14'(i)]), 64'(pat(256 + i)));
    endtask

    task automatic t_freeze();
        logic [63:0] v;
        int h0;
        wr(8'h80, 64'h0);
        wr(8'h88, 64'h40100);
        wr(8'h90, 64'd16);
        h0 = hs_count;
        wr(8'h98, 64'h1);
        wr(8'h80, 64'hDEAD);
        wr(8'h90, 64'd5);
        wr(8'h98, 64'h7);
        rd(8'h80, v); check("R4 src frozen", v, 0);
        rd(8'h90, v); check("R4 cnt frozen", v, 16);
        rd(8'h98, v); check("R4 cmd frozen", v, 1);
        wait_idle();
        repeat (2) @(negedge clk);
        check("R4 count used", 64'(hs_count - h0), 16);
    endtask

    task automatic reject_case(input string req, input logic [63:0] b, input logic [63:0] n);
        logic [63:0] v;
        int h0 = hs_count;
        wr(8'h80, 64'h0);
        wr(8'h88, b);
        wr(8'h90, n);
        wr(8'h98, 64'h1);
        wait_idle();
        rd(8'h98, v); check(req, v, 64'h8);
        check(req, 64'(hs_count - h0), 0);
    endtask

    task automatic t_window();
        logic [63:0] v;
        int h0;
        reject_case("R7 below base", 64'h3FFFF, 64'd1);
        reject_case("R7 zero count", 64'h40000, 64'd0);
        reject_case("R7 end at top", 64'h40FFF, 64'd1);
        reject_case("R7 wrap", 64'h40000, 64'hFFFF_FFFF_FFFF_FFFF);
        reject_case("R7 at top", 64'h41000, 64'd1);
        h0 = hs_count;
        wr(8'h88, 64'h40FFE);
        wr(8'h90, 64'd1);
        wr(8'h98, 64'h1);
        wait_idle();
        rd(8'h98, v); check("R7 accept clears err", v, 0);
        check("R7 accepted edge", 64'(hs_count - h0), 1);
    endtask

    initial begin
        reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        for (int i = 0; i < 16384; i++) host_mem[i] = pat(i);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_norun();
        t_round_trip();
        t_freeze();
        t_window();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule